// File: doc/BRIEF.md
# Bi-weighted prediction sample combiner

This block merges two streams of signed 16-bit intermediate prediction samples into a single stream of unsigned 8-bit pixels. Each source gets its own signed weight, and a common rounding bias is added. Each accepted beat carries four horizontally adjacent sample pairs, and each output beat carries four pixels. The per-lane result is the weighted sum of the level-shifted sources, plus a rounding term built from the two offsets. That sum is shifted right arithmetically by a configurable amount and then clamped to 0..255.

Configuration is a one-cycle `cfg_load` pulse. It captures the weights, offsets, level shifts, shift amount and region size. It also starts a new region. On the next cycle the block folds every constant term into one registered bias, so each lane only multiplies, adds, shifts and clamps. Input is refused until that bias is in place.

Every output beat is tagged with the row and column of its left-most pixel, so a downstream writer can place it. Beats are ordered in tiles four rows tall: the columns of one row run left to right, then the next row of the same tile follows. A new region may be loaded only when the pipeline is empty.

Back-pressure rules:
- Input is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- Output is consumed on an edge where `out_valid` and `out_ready` are both high.
- While `out_valid` is high and `out_ready` is low, all three pipeline stages hold their contents and `in_ready` stays low.

Top module: `biwp_top`

## Requirements
- R1: Each lane outputs the clamp of (((a+la)*wa + (b+lb)*wb + ((oa+ob+1) << (s-1))) >>> s), evaluated with 32-bit two's-complement arithmetic. Here a and b are that lane's samples from `in_a` and `in_b`, wa/wb are the weights, oa/ob the offsets, la/lb the level shifts and s the shift amount.
- R2: The shifted value is saturated to 0..65535 and then to 0..255. Any negative result gives 0, and any result above 255 gives 255.
- R3: The shift amount may be any value from 1 to 20. The shift is arithmetic, and the rounding offsets are scaled by 2^(s-1).
- R4: Lane i takes bits [16i+15:16i] of `in_a` and `in_b` and drives bits [8i+7:8i] of `out_pix`. Lanes do not affect one another.
- R5: With `out_ready` held high, the pixels of an input beat accepted on rising edge k appear, with `out_valid` high, after edge k+2.
- R6: While `out_valid` is high and `out_ready` is low, `out_pix`, `out_row`, `out_col` and `out_valid` hold their values and `in_ready` is low.
- R7: `in_ready` is low from reset until a load, and it is low in the cycle that follows a `cfg_load` edge. It may rise one cycle later.
- R8: Output beats of a W×H region come in this order. Columns 0, 4, … W-4 of a row come first, then the next row of the same four-row tile. After the fourth row, the next tile starts at column 0. `out_row` and `out_col` give the row and first column of the beat.
- R9: A load with width 0 or height 0 leaves `in_ready` low and produces no output beats.
- R10: After W·H/4 input beats of the region have been accepted, `in_ready` stays low until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Captures the configuration and starts a region |
| cfg_wgt_a | input | 16 | Signed weight of source A |
| cfg_wgt_b | input | 16 | Signed weight of source B |
| cfg_off_a | input | 16 | Signed offset A |
| cfg_off_b | input | 16 | Signed offset B |
| cfg_lvl_a | input | 16 | Signed level shift of source A |
| cfg_lvl_b | input | 16 | Signed level shift of source B |
| cfg_shift | input | 5 | Right-shift amount, 1..20 |
| cfg_width | input | 16 | Region width in pixels, multiple of 4 |
| cfg_height | input | 16 | Region height in rows, multiple of 4 |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts an input beat |
| in_a | input | 64 | Four signed 16-bit samples of source A |
| in_b | input | 64 | Four signed 16-bit samples of source B |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_pix | output | 32 | Four unsigned 8-bit pixels |
| out_row | output | 16 | Row of the output beat |
| out_col | output | 16 | First column of the output beat |

## Verification
An accepted beat is due two rising edges after its acceptance edge, provided no stall occurs. The bench pushes a beat and then checks `out_valid` at the next three falling edges, expecting low, low, then high with the computed pixels.

After a `cfg_load` edge, `in_ready` is checked low at the first falling edge and high at the second. During a stall, the held outputs are sampled several falling edges apart and compared with each other.

Output beats are collected only at falling edges where `out_valid` and `out_ready` are both high. The bench changes `out_ready` one nanosecond after a rising edge, so each collected beat is exactly the beat consumed at the following rising edge.

// File: rtl/biwp_pkg.sv
package biwp_pkg;
  localparam int LANES   = 4;
  localparam int SAMP_W  = 16;
  localparam int WGT_W   = 16;
  localparam int PIX_W   = 8;
  localparam int ACC_W   = 32;
  localparam int SHIFT_W = 5;
  localparam int DIM_W   = 16;
  localparam int ROWS_PER_TILE = 4;
endpackage

// File: rtl/biwp_bias.sv
// Captures configuration on load and folds constants into one bias one cycle later.
module biwp_bias #(
  parameter int WGT_W   = 16,
  parameter int SHIFT_W = 5,
  parameter int ACC_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic signed [WGT_W-1:0]   wgt_a,
  input  logic signed [WGT_W-1:0]   wgt_b,
  input  logic signed [WGT_W-1:0]   off_a,
  input  logic signed [WGT_W-1:0]   off_b,
  input  logic signed [WGT_W-1:0]   lvl_a,
  input  logic signed [WGT_W-1:0]   lvl_b,
  input  logic [SHIFT_W-1:0]        shamt,
  output logic signed [WGT_W-1:0]   wgt_a_q,
  output logic signed [WGT_W-1:0]   wgt_b_q,
  output logic [SHIFT_W-1:0]        shamt_q,
  output logic signed [ACC_W-1:0]   bias_q,
  output logic                      bias_ok
);
  logic signed [WGT_W-1:0] off_a_q, off_b_q, lvl_a_q, lvl_b_q;
  logic                    pend_q;
  logic signed [ACC_W-1:0] la, lb, wa, wb, oa, ob, rnd, fold;

  always_comb begin
    la   = lvl_a_q;
    lb   = lvl_b_q;
    wa   = wgt_a_q;
    wb   = wgt_b_q;
    oa   = off_a_q;
    ob   = off_b_q;
    rnd  = (oa + ob + ACC_W'(1)) <<< (shamt_q - SHIFT_W'(1));
    fold = la * wa + lb * wb + rnd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wgt_a_q <= '0;
      wgt_b_q <= '0;
      off_a_q <= '0;
      off_b_q <= '0;
      lvl_a_q <= '0;
      lvl_b_q <= '0;
      shamt_q <= SHIFT_W'(1);
      bias_q  <= '0;
      pend_q  <= 1'b0;
      bias_ok <= 1'b0;
    end else if (load) begin
      wgt_a_q <= wgt_a;
      wgt_b_q <= wgt_b;
      off_a_q <= off_a;
      off_b_q <= off_b;
      lvl_a_q <= lvl_a;
      lvl_b_q <= lvl_b;
      shamt_q <= shamt;
      pend_q  <= 1'b1;
      bias_ok <= 1'b0;
    end else if (pend_q) begin
      bias_q  <= fold;
      pend_q  <= 1'b0;
      bias_ok <= 1'b1;
    end
  end
endmodule

// File: rtl/biwp_pos.sv
// Region walker: four-row tiles, row-major inside a tile.
module biwp_pos #(
  parameter int DIM_W = 16,
  parameter int STEP  = 4,
  parameter int TILE  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  logic             step,
  output logic             active,
  output logic [DIM_W-1:0] row,
  output logic [DIM_W-1:0] col
);
  localparam int SUB_W = (TILE > 1) ? $clog2(TILE) : 1;

  logic [DIM_W-1:0] wid_q, hgt_q, tile_q, col_q;
  logic [SUB_W-1:0] sub_q;
  logic             row_end, tile_end, last;

  assign row_end  = (col_q + DIM_W'(STEP)) == wid_q;
  assign tile_end = sub_q == SUB_W'(TILE - 1);
  assign last     = row_end && tile_end && ((tile_q + DIM_W'(TILE)) == hgt_q);
  assign row      = tile_q + DIM_W'(sub_q);
  assign col      = col_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wid_q  <= '0;
      hgt_q  <= '0;
      tile_q <= '0;
      col_q  <= '0;
      sub_q  <= '0;
      active <= 1'b0;
    end else if (load) begin
      wid_q  <= width;
      hgt_q  <= height;
      tile_q <= '0;
      col_q  <= '0;
      sub_q  <= '0;
      active <= (width != '0) && (height != '0);
    end else if (step && active) begin
      if (!row_end) begin
        col_q <= col_q + DIM_W'(STEP);
      end else begin
        col_q <= '0;
        if (!tile_end) begin
          sub_q <= sub_q + SUB_W'(1);
        end else begin
          sub_q  <= '0;
          tile_q <= tile_q + DIM_W'(TILE);
        end
      end
      if (last) active <= 1'b0;
    end
  end
endmodule

// File: rtl/biwp_lane.sv
// One lane: multiply, add bias, shift and two-step saturate.
module biwp_lane #(
  parameter int SAMP_W  = 16,
  parameter int WGT_W   = 16,
  parameter int ACC_W   = 32,
  parameter int SHIFT_W = 5,
  parameter int PIX_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [SAMP_W-1:0]        smp_a,
  input  logic [SAMP_W-1:0]        smp_b,
  input  logic signed [WGT_W-1:0]  wgt_a,
  input  logic signed [WGT_W-1:0]  wgt_b,
  input  logic signed [ACC_W-1:0]  bias,
  input  logic [SHIFT_W-1:0]       shamt,
  output logic [PIX_W-1:0]         pix
);
  localparam int MID_W = 2 * PIX_W;
  localparam logic signed [ACC_W-1:0] MID_MAX = ACC_W'((1 << MID_W) - 1);
  localparam logic [MID_W-1:0]        PIX_MAX = MID_W'((1 << PIX_W) - 1);

  logic signed [ACC_W-1:0] ext_a, ext_b, ext_wa, ext_wb;
  logic signed [ACC_W-1:0] prod_a_q, prod_b_q, sum_q, shifted;
  logic [MID_W-1:0]        mid;
  logic [PIX_W-1:0]        narrow;

  always_comb begin
    ext_a   = $signed(smp_a);
    ext_b   = $signed(smp_b);
    ext_wa  = wgt_a;
    ext_wb  = wgt_b;
    shifted = sum_q >>> shamt;
    if (shifted < 0)             mid = '0;
    else if (shifted > MID_MAX)  mid = '1;
    else                         mid = shifted[MID_W-1:0];
    narrow = (mid > PIX_MAX) ? '1 : mid[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_a_q <= '0;
      prod_b_q <= '0;
      sum_q    <= '0;
      pix      <= '0;
    end else if (en) begin
      prod_a_q <= ext_a * ext_wa;
      prod_b_q <= ext_b * ext_wb;
      sum_q    <= prod_a_q + prod_b_q + bias;
      pix      <= narrow;
    end
  end
endmodule

// File: rtl/biwp_top.sv
module biwp_top
  import biwp_pkg::*;
#(
  parameter int NL   = LANES,
  parameter int SW   = SAMP_W,
  parameter int WW   = WGT_W,
  parameter int PW   = PIX_W,
  parameter int AW   = ACC_W,
  parameter int SHW  = SHIFT_W,
  parameter int DW   = DIM_W,
  parameter int TROW = ROWS_PER_TILE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [WW-1:0]    cfg_wgt_a,
  input  logic [WW-1:0]    cfg_wgt_b,
  input  logic [WW-1:0]    cfg_off_a,
  input  logic [WW-1:0]    cfg_off_b,
  input  logic [WW-1:0]    cfg_lvl_a,
  input  logic [WW-1:0]    cfg_lvl_b,
  input  logic [SHW-1:0]   cfg_shift,
  input  logic [DW-1:0]    cfg_width,
  input  logic [DW-1:0]    cfg_height,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NL*SW-1:0] in_a,
  input  logic [NL*SW-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [NL*PW-1:0] out_pix,
  output logic [DW-1:0]    out_row,
  output logic [DW-1:0]    out_col
);
  localparam int STAGES = 3;

  logic signed [WW-1:0] wa_q, wb_q;
  logic [SHW-1:0]       sh_q;
  logic signed [AW-1:0] bias_q;
  logic                 bias_ok, active, adv, take;
  logic [DW-1:0]        pos_row, pos_col;
  logic [STAGES-1:0]    vld_q;
  logic [DW-1:0]        row_q [STAGES];
  logic [DW-1:0]        col_q [STAGES];

  assign adv       = !vld_q[STAGES-1] || out_ready;
  assign in_ready  = active && bias_ok && adv;
  assign take      = in_valid && in_ready;
  assign out_valid = vld_q[STAGES-1];
  assign out_row   = row_q[STAGES-1];
  assign out_col   = col_q[STAGES-1];

  biwp_bias #(.WGT_W(WW), .SHIFT_W(SHW), .ACC_W(AW)) u_bias (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .wgt_a($signed(cfg_wgt_a)), .wgt_b($signed(cfg_wgt_b)),
    .off_a($signed(cfg_off_a)), .off_b($signed(cfg_off_b)),
    .lvl_a($signed(cfg_lvl_a)), .lvl_b($signed(cfg_lvl_b)),
    .shamt(cfg_shift),
    .wgt_a_q(wa_q), .wgt_b_q(wb_q), .shamt_q(sh_q),
    .bias_q(bias_q), .bias_ok(bias_ok)
  );

  biwp_pos #(.DIM_W(DW), .STEP(NL), .TILE(TROW)) u_pos (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .width(cfg_width), .height(cfg_height), .step(take),
    .active(active), .row(pos_row), .col(pos_col)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int s = 0; s < STAGES; s++) begin
        row_q[s] <= '0;
        col_q[s] <= '0;
      end
    end else if (adv) begin
      vld_q    <= {vld_q[STAGES-2:0], take};
      row_q[0] <= pos_row;
      col_q[0] <= pos_col;
      for (int s = 1; s < STAGES; s++) begin
        row_q[s] <= row_q[s-1];
        col_q[s] <= col_q[s-1];
      end
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_lane
    biwp_lane #(.SAMP_W(SW), .WGT_W(WW), .ACC_W(AW), .SHIFT_W(SHW), .PIX_W(PW)) u_lane (
      .clk(clk), .rst_n(rst_n), .en(adv),
      .smp_a(in_a[g*SW +: SW]), .smp_b(in_b[g*SW +: SW]),
      .wgt_a(wa_q), .wgt_b(wb_q), .bias(bias_q), .shamt(sh_q),
      .pix(out_pix[g*PW +: PW])
    );
  end
endmodule

// File: rtl/biwp_chk.sv
module biwp_chk #(
  parameter int NL  = 4,
  parameter int SW  = 16,
  parameter int WW  = 16,
  parameter int PW  = 8,
  parameter int SHW = 5,
  parameter int DW  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load,
  input logic [DW-1:0]    cfg_width,
  input logic [DW-1:0]    cfg_height,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [NL*PW-1:0] out_pix,
  input logic [DW-1:0]    out_row,
  input logic [DW-1:0]    out_col
);
  logic [31:0]   total_q, cnt_q;
  logic [DW-1:0] w_q, h_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total_q <= '0;
      cnt_q   <= '0;
      w_q     <= '0;
      h_q     <= '0;
    end else if (cfg_load) begin
      total_q <= 32'(cfg_width / DW'(NL)) * 32'(cfg_height);
      cnt_q   <= '0;
      w_q     <= cfg_width;
      h_q     <= cfg_height;
    end else if (in_valid && in_ready) begin
      cnt_q <= cnt_q + 32'd1;
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_row) && $stable(out_col));

  // R6
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R7
  cfg_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !in_ready);

  // R10
  region_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == total_q) |-> !in_ready);

  // R8
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_row < h_q) && (out_col < w_q) && ((out_col % DW'(NL)) == '0));
endmodule

bind biwp_top biwp_chk #(.NL(NL), .SW(SW), .WW(WW), .PW(PW), .SHW(SHW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_width(cfg_width),
  .cfg_height(cfg_height), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
  .out_row(out_row), .out_col(out_col)
);

// File: tb/biwp_top_test.sv
`timescale 1ns/1ps
module biwp_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_wgt_a = '0, cfg_wgt_b = '0, cfg_off_a = '0, cfg_off_b = '0;
  logic [15:0] cfg_lvl_a = '0, cfg_lvl_b = '0, cfg_width = '0, cfg_height = '0;
  logic [4:0]  cfg_shift = 5'd1;
  logic        in_valid = 1'b0, in_ready;
  logic [63:0] in_a = '0, in_b = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [31:0] out_pix;
  logic [15:0] out_row, out_col;

  int checks = 0, errors = 0;
  int c_wa, c_wb, c_oa, c_ob, c_la, c_lb, c_sh, c_wd;
  int ncap = 0;
  logic [31:0] cap_pix [64];
  int cap_row [64], cap_col [64];
  logic [31:0] exp_pix [64];
  int lane_a [4], lane_b [4];

  always #2 clk = ~clk;

  biwp_top uut (.*);

  always @(negedge clk) begin
    if (out_valid && out_ready && ncap < 64) begin
      cap_pix[ncap] = out_pix;
      cap_row[ncap] = int'(out_row);
      cap_col[ncap] = int'(out_col);
      ncap = ncap + 1;
    end
  end

  initial begin
    #(4 * 150000);
    errors = errors + 1;
    $display("FAIL watchdog: run did not finish, actual hung, expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(input int a, input int b);
    longint t;
    t = longint'(a + c_la) * c_wa + longint'(b + c_lb) * c_wb
        + (longint'(c_oa + c_ob + 1) <<< (c_sh - 1));
    t = t >>> c_sh;
    if (t < 0) return 0;
    if (t > 255) return 255;
    return int'(t);
  endfunction

  task automatic load(input int wa, input int wb, input int oa, input int ob,
                      input int sh, input int la, input int lb, input int wd, input int ht);
    c_wa = wa; c_wb = wb; c_oa = oa; c_ob = ob; c_sh = sh; c_la = la; c_lb = lb; c_wd = wd;
    cfg_wgt_a = 16'(wa); cfg_wgt_b = 16'(wb); cfg_off_a = 16'(oa); cfg_off_b = 16'(ob);
    cfg_lvl_a = 16'(la); cfg_lvl_b = 16'(lb); cfg_shift = 5'(sh);
    cfg_width = 16'(wd); cfg_height = 16'(ht);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    ncap = 0;
  endtask

  task automatic push(input int k);
    for (int i = 0; i < 4; i++) begin
      in_a[16*i +: 16] = 16'(lane_a[i]);
      in_b[16*i +: 16] = 16'(lane_b[i]);
      exp_pix[k][8*i +: 8] = 8'(model(lane_a[i], lane_b[i]));
    end
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic gen(input int k, input int salt);
    for (int i = 0; i < 4; i++) begin
      lane_a[i] = ((k * 37 + i * 911 + salt * 53) % 4000) - 1500;
      lane_b[i] = ((k * 71 + i * 313 + salt * 29) % 3000) - 900;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic verify(input int n, input string req);
    int vpr;
    vpr = c_wd / 4;
    chk(ncap == n, req, ncap, n);
    for (int k = 0; k < n && k < ncap; k++) begin
      int er, ec;
      er = (k / (4 * vpr)) * 4 + (k % (4 * vpr)) / vpr;
      ec = (k % vpr) * 4;
      chk(cap_pix[k] == exp_pix[k], req, cap_pix[k], exp_pix[k]);
      chk(cap_row[k] == er && cap_col[k] == ec, {req, " R8 position"},
          cap_row[k] * 65536 + cap_col[k], er * 65536 + ec);
    end
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b0, "R7 reset ready", in_ready, 0);
    chk(out_valid == 1'b0, "R7 reset valid", out_valid, 0);
  endtask

  task automatic t_latency();
    load(1, 1, 0, 0, 7, 8192, 8192, 4, 4);
    chk(in_ready == 1'b0, "R7 ready after load", in_ready, 0);
    @(negedge clk);
    chk(in_ready == 1'b1, "R7 ready one cycle later", in_ready, 1);
    lane_a = '{0, 100, -8192, 8000};
    lane_b = '{0, 100, -8192, 8000};
    push(0);
    chk(out_valid == 1'b0, "R5 latency edge k", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 latency edge k+1", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R5 latency edge k+2", out_valid, 1);
    chk(out_pix == exp_pix[0], "R1 R4 first beat", out_pix, exp_pix[0]);
    for (int k = 1; k < 4; k++) begin
      gen(k, 3);
      push(k);
    end
    idle(6);
    verify(4, "R1 R4 unit weights");
  endtask

  task automatic t_region();
    load(3, -2, 5, -3, 9, 100, -50, 8, 8);
    idle(1);
    for (int k = 0; k < 16; k++) begin
      gen(k, 7);
      push(k);
    end
    idle(6);
    verify(16, "R1 R4 8x8 region");
    chk(in_ready == 1'b0, "R10 ready low after region", in_ready, 0);
    lane_a = '{1, 1, 1, 1};
    lane_b = '{1, 1, 1, 1};
    in_valid = 1'b1;
    idle(5);
    in_valid = 1'b0;
    chk(ncap == 16, "R10 no extra beats", ncap, 16);
  endtask

  task automatic t_clamp();
    load(64, 64, 0, 0, 1, 0, 0, 4, 4);
    idle(1);
    lane_a = '{1, -1000, 3, 30000};
    lane_b = '{1, -1000, 0, 30000};
    push(0);
    lane_a = '{2, 5, -32768, 600};
    lane_b = '{1, -5, -32768, 0};
    push(1);
    idle(6);
    verify(2, "R2 clamp");
    chk(cap_pix[0][15:8] == 8'd0, "R2 negative to zero", cap_pix[0][15:8], 0);
    chk(cap_pix[0][31:24] == 8'd255, "R2 large to 255", cap_pix[0][31:24], 255);
    chk(cap_pix[0][7:0] == 8'd64, "R2 in range", cap_pix[0][7:0], 64);
  endtask

  task automatic t_round();
    load(1000, 1000, 127, 0, 20, 0, 0, 4, 4);
    idle(1);
    lane_a = '{30000, 0, -30000, 1234};
    lane_b = '{30000, 0, 100, -77};
    push(0);
    idle(6);
    verify(1, "R3 shift 20");
    chk(cap_pix[0][15:8] == 8'd64, "R3 rounding term only", cap_pix[0][15:8], 64);
    load(-3, 1, -2, -1, 3, 4, -4, 4, 4);
    idle(1);
    for (int k = 0; k < 4; k++) begin
      lane_a[k] = -40 + k * 9;
      lane_b[k] = 700 - k * 150;
    end
    push(0);
    idle(6);
    verify(1, "R3 negative weight shift 3");
  endtask

  task automatic t_stall();
    load(2, 1, 1, 1, 4, 10, 20, 4, 4);
    idle(1);
    @(posedge clk); #1 out_ready = 1'b0;
    @(negedge clk);
    lane_a = '{500, -500, 20, 1000};
    lane_b = '{10, 300, -20, 2000};
    push(0);
    idle(4);
    chk(out_valid == 1'b1, "R6 valid held", out_valid, 1);
    chk(in_ready == 1'b0, "R6 ready low in stall", in_ready, 0);
    chk(out_pix == exp_pix[0], "R6 held pixels", out_pix, exp_pix[0]);
    idle(3);
    chk(out_pix == exp_pix[0] && out_valid, "R6 pixels stable", out_pix, exp_pix[0]);
    chk(ncap == 0, "R6 nothing consumed", ncap, 0);
    @(posedge clk); #1 out_ready = 1'b1;
    idle(3);
    verify(1, "R6 release");
  endtask

  task automatic t_zero();
    load(1, 1, 0, 0, 6, 0, 0, 0, 8);
    for (int i = 0; i < 4; i++) begin
      chk(in_ready == 1'b0, "R9 zero width", in_ready, 0);
      @(negedge clk);
    end
    load(1, 1, 0, 0, 6, 0, 0, 8, 0);
    in_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk(in_ready == 1'b0, "R9 zero height", in_ready, 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    idle(4);
    chk(ncap == 0, "R9 no beats", ncap, 0);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_region();
    t_clamp();
    t_round();
    t_stall();
    t_zero();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule